// File: doc/BRIEF.md
# Two-Tier Interrupt Combiner and Priority Router

This block gathers 128 interrupt events and presents one maskable interrupt level to a CPU, plus a separate non-maskable pulse. Each event input is edge-detected into a sticky flag. The flags fall into four groups of 32. In each group a combiner ORs together the flags that are not masked.

Twelve selector registers, one for each core level 4 to 15, pick what drives that level. A selector can pick one of the four combiner outputs, with codes 0 to 3. It can instead pick a single event directly, with codes 4 to 127. An event picked directly no longer counts in its combiner.

A core stage registers the twelve level lines into a pending register. It gates them with a per-level enable and reports the most urgent active level, where level 4 is the most urgent and level 15 the least. Software reads and writes flags, clears, masks, selectors and enables over a single-cycle word-addressed register bus. CPU vectoring and context save are outside the block.

Top module: `intc_cascade`

## Requirements
- R1: After reset all flags and pending bits are 0, every mask bit is 1 (masked), the core enable word is 0, and irq_valid_o is 0. The selectors of levels 12, 13, 14 and 15 read 0x80, 0x81, 0x82 and 0x83 (combiners 0 to 3, enabled). The selectors of levels 4 to 11 read 0.
- R2: The flag of event n (4 to 127) sets at the first clock edge where evt_i[n] is 1 and was 0 at the previous edge. It stays set until a 1 is written to bit n%32 of clear word n/32. If a rising edge and a clear of the same flag fall in one cycle, the flag is set.
- R3: Event inputs 0 to 3 never set a flag, because those codes name the combiner outputs; flag word 0 bits 3:0 always read 0.
- R4: Combiner g outputs the OR, over events 32g to 32g+31, of flag AND NOT mask. An event chosen directly by any enabled selector is left out.
- R5: Selector word for level L sits at address 0x10+L-4, with bit 7 = route enable and bits 6:0 = event code. When enabled, code 0 to 3 drives level L from that combiner. Code 4 to 127 drives it from that event's flag, and the mask has no effect. A disabled selector drives 0. One combiner may drive several levels.
- R6: The pending register (address 0x21, bits 15:4) captures the twelve level lines one clock after the flags they derive from; bits 3:0 read 0.
- R7: irq_valid_o is 1 exactly when some level has pending AND enable (enable word at 0x20, bits 15:4 writable, bits 3:0 read 0). irq_level_o is then the lowest-numbered such level.
- R8: nmi_o is high for exactly one cycle, the cycle after the clock edge at which nmi_i is first seen high, whatever the enables and masks are.
- R9: Register map: flag words 0x00 to 0x03 (read-only, writes ignored); clear words 0x04 to 0x07 (write-one-to-clear, read 0); mask words 0x08 to 0x0B; selectors 0x10 to 0x1B; enable 0x20; pending 0x21 (read-only). All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 128 | Event inputs, synchronous to clk_i |
| nmi_i | input | 1 | Non-maskable request level |
| bus_we_i | input | 1 | Register write strobe, one word per cycle |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_valid_o | output | 1 | A maskable level is pending and enabled |
| irq_level_o | output | 4 | Most urgent active level (4 to 15) |
| nmi_o | output | 1 | One-cycle non-maskable pulse |

## Verification
The assertions take evt_i, nmi_i and the bus as synchronous to clk_i and stable around each rising edge. They also take each bus write as lasting one cycle, with its effect visible after that edge. The bench drives every input on the falling edge and holds it for a full cycle, so edges, clears and selector changes always land on a clean rising edge. Random event toggles are sparse, and random writes hit only one register per cycle, which keeps the flag, clear and routing interplay within those assumptions.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int EVT_N   = 128;
  localparam int GRP_W   = 32;
  localparam int CMB_N   = EVT_N / GRP_W;
  localparam int LVL_N   = 16;
  localparam int LVL_LO  = 4;
  localparam int SEL_N   = LVL_N - LVL_LO;
  localparam int EVT_W   = $clog2(EVT_N);
  localparam int LVL_W   = $clog2(LVL_N);
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int A_FLAG  = 0;
  localparam int A_CLR   = A_FLAG + CMB_N;
  localparam int A_MASK  = A_CLR + CMB_N;
  localparam int A_SEL   = 16;
  localparam int A_EN    = 32;
  localparam int A_PEND  = 33;
endpackage

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int EVT_N  = intc_pkg::EVT_N,
  parameter int SRC_LO = intc_pkg::CMB_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [EVT_N-1:0] clr_i,
  output logic [EVT_N-1:0] flag_o
);
  localparam logic [EVT_N-1:0] SRC_M = {{(EVT_N-SRC_LO){1'b1}}, {SRC_LO{1'b0}}};

  logic [EVT_N-1:0] evt_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      flag_q <= '0;
    end else begin
      evt_q  <= evt_i;
      // set wins over a clear in the same cycle
      flag_q <= (flag_q & ~clr_i) | (evt_i & ~evt_q & SRC_M);
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R2
  AST_FLAG_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((flag_q & ~$past(flag_q) & ~($past(evt_i) & ~$past(evt_q))) == '0)); // R2
endmodule

// File: rtl/intc_combiner.sv
module intc_combiner #(
  parameter int GRP_W = intc_pkg::GRP_W
) (
  input  logic [GRP_W-1:0] flag_i,
  input  logic [GRP_W-1:0] mask_i,
  input  logic [GRP_W-1:0] bypass_i,
  output logic             out_o
);
  assign out_o = |(flag_i & ~mask_i & ~bypass_i);
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int EVT_N = intc_pkg::EVT_N,
  parameter int CMB_N = intc_pkg::CMB_N,
  parameter int SEL_N = intc_pkg::SEL_N,
  parameter int EVT_W = intc_pkg::EVT_W
) (
  input  logic [SEL_N-1:0]            sel_en_i,
  input  logic [SEL_N-1:0][EVT_W-1:0] sel_ev_i,
  input  logic [EVT_N-1:0]            flag_i,
  input  logic [CMB_N-1:0]            cmb_i,
  output logic [EVT_N-1:0]            bypass_o,
  output logic [SEL_N-1:0]            line_o
);
  localparam int CMB_W = (CMB_N > 1) ? $clog2(CMB_N) : 1;

  always_comb begin
    bypass_o = '0;
    for (int l = 0; l < SEL_N; l++) begin
      if (sel_en_i[l] && (sel_ev_i[l] >= EVT_W'(CMB_N))) bypass_o[sel_ev_i[l]] = 1'b1;
    end
  end

  always_comb begin
    for (int l = 0; l < SEL_N; l++) begin
      if (!sel_en_i[l])                    line_o[l] = 1'b0;
      else if (sel_ev_i[l] < EVT_W'(CMB_N)) line_o[l] = cmb_i[sel_ev_i[l][CMB_W-1:0]];
      else                                 line_o[l] = flag_i[sel_ev_i[l]];
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core #(
  parameter int LVL_N  = intc_pkg::LVL_N,
  parameter int LVL_LO = intc_pkg::LVL_LO,
  parameter int SEL_N  = intc_pkg::SEL_N,
  parameter int LVL_W  = intc_pkg::LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_N-1:0] line_i,
  input  logic [LVL_N-1:0] en_i,
  input  logic             nmi_i,
  output logic [LVL_N-1:0] pend_o,
  output logic             irq_valid_o,
  output logic [LVL_W-1:0] irq_level_o,
  output logic             nmi_o
);
  logic [LVL_N-1:0] pend_q, act;
  logic             nmi_q, nmi_pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      nmi_q       <= 1'b0;
      nmi_pulse_q <= 1'b0;
    end else begin
      pend_q      <= {line_i, {LVL_LO{1'b0}}};
      nmi_q       <= nmi_i;
      nmi_pulse_q <= nmi_i & ~nmi_q;
    end
  end

  assign act = pend_q & en_i;

  // scan down so the lowest-numbered active level is written last
  always_comb begin
    irq_valid_o = 1'b0;
    irq_level_o = '0;
    for (int l = LVL_N - 1; l >= LVL_LO; l--) begin
      if (act[l]) begin
        irq_valid_o = 1'b1;
        irq_level_o = LVL_W'(l);
      end
    end
  end

  assign pend_o = pend_q;
  assign nmi_o  = nmi_pulse_q;

  AST_PEND_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (pend_q[LVL_N-1:LVL_LO] == $past(line_i))); // R6
  AST_IRQ_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (pend_q[irq_level_o] && en_i[irq_level_o])); // R7
  AST_IRQ_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ((act & ((LVL_N'(1) << irq_level_o) - LVL_N'(1))) == '0)); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> ((pend_q & en_i) == '0)); // R7
  AST_NMI_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o); // R8
endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
  import intc_pkg::*;
#(
  parameter int EVT_N_P  = EVT_N,
  parameter int ADDR_W_P = ADDR_W,
  parameter int DATA_W_P = DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [EVT_N_P-1:0]  evt_i,
  input  logic                nmi_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W_P-1:0] bus_addr_i,
  input  logic [DATA_W_P-1:0] bus_wdata_i,
  output logic [DATA_W_P-1:0] bus_rdata_o,
  output logic                irq_valid_o,
  output logic [LVL_W-1:0]    irq_level_o,
  output logic                nmi_o
);
  localparam int CMB_LVL0 = LVL_N - CMB_N;
  localparam logic [LVL_N-1:0] EN_M = ~((LVL_N'(1) << LVL_LO) - LVL_N'(1));

  logic [EVT_N_P-1:0]            flag, clr, byp;
  logic [CMB_N-1:0][GRP_W-1:0]   mask_q;
  logic [SEL_N-1:0]              sel_en_q;
  logic [SEL_N-1:0][EVT_W-1:0]   sel_ev_q;
  logic [LVL_N-1:0]              en_q, pend;
  logic [CMB_N-1:0]              cmb;
  logic [SEL_N-1:0]              line;

  always_comb begin
    clr = '0;
    for (int g = 0; g < CMB_N; g++) begin
      if (bus_we_i && bus_addr_i == ADDR_W_P'(A_CLR + g)) clr[g*GRP_W +: GRP_W] = bus_wdata_i[GRP_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      en_q   <= '0;
      for (int l = 0; l < SEL_N; l++) begin
        sel_en_q[l] <= (l + LVL_LO >= CMB_LVL0);
        sel_ev_q[l] <= (l + LVL_LO >= CMB_LVL0) ? EVT_W'(l + LVL_LO - CMB_LVL0) : '0;
      end
    end else if (bus_we_i) begin
      for (int g = 0; g < CMB_N; g++) begin
        if (bus_addr_i == ADDR_W_P'(A_MASK + g)) mask_q[g] <= bus_wdata_i[GRP_W-1:0];
      end
      for (int l = 0; l < SEL_N; l++) begin
        if (bus_addr_i == ADDR_W_P'(A_SEL + l)) begin
          sel_en_q[l] <= bus_wdata_i[EVT_W];
          sel_ev_q[l] <= bus_wdata_i[EVT_W-1:0];
        end
      end
      if (bus_addr_i == ADDR_W_P'(A_EN)) en_q <= bus_wdata_i[LVL_N-1:0] & EN_M;
    end
  end

  intc_flags #(.EVT_N(EVT_N_P), .SRC_LO(CMB_N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr),
    .flag_o (flag)
  );

  for (genvar g = 0; g < CMB_N; g++) begin : g_cmb
    intc_combiner #(.GRP_W(GRP_W)) u_cmb (
      .flag_i   (flag[g*GRP_W +: GRP_W]),
      .mask_i   (mask_q[g]),
      .bypass_i (byp[g*GRP_W +: GRP_W]),
      .out_o    (cmb[g])
    );
  end

  intc_route #(.EVT_N(EVT_N_P), .CMB_N(CMB_N), .SEL_N(SEL_N), .EVT_W(EVT_W)) u_route (
    .sel_en_i (sel_en_q),
    .sel_ev_i (sel_ev_q),
    .flag_i   (flag),
    .cmb_i    (cmb),
    .bypass_o (byp),
    .line_o   (line)
  );

  intc_core #(.LVL_N(LVL_N), .LVL_LO(LVL_LO), .SEL_N(SEL_N), .LVL_W(LVL_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line),
    .en_i        (en_q),
    .nmi_i       (nmi_i),
    .pend_o      (pend),
    .irq_valid_o (irq_valid_o),
    .irq_level_o (irq_level_o),
    .nmi_o       (nmi_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int g = 0; g < CMB_N; g++) begin
      if (bus_addr_i == ADDR_W_P'(A_FLAG + g)) bus_rdata_o = DATA_W_P'(flag[g*GRP_W +: GRP_W]);
      if (bus_addr_i == ADDR_W_P'(A_MASK + g)) bus_rdata_o = DATA_W_P'(mask_q[g]);
    end
    for (int l = 0; l < SEL_N; l++) begin
      if (bus_addr_i == ADDR_W_P'(A_SEL + l)) bus_rdata_o = DATA_W_P'({sel_en_q[l], sel_ev_q[l]});
    end
    if (bus_addr_i == ADDR_W_P'(A_EN))   bus_rdata_o = DATA_W_P'(en_q);
    if (bus_addr_i == ADDR_W_P'(A_PEND)) bus_rdata_o = DATA_W_P'(pend);
  end

  AST_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q[LVL_LO-1:0] == '0); // R7
  AST_DIRECT_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_en_q[0] && sel_ev_q[0] >= EVT_W'(CMB_N)) |-> (line[0] == flag[sel_ev_q[0]])); // R5
endmodule

// File: tb/sim_intc_cascade.sv
module sim_intc_cascade;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt = '0;
  logic         nmi = 1'b0;
  logic         we = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq_valid, nmi_out;
  logic [3:0]   irq_level;

  always #5 clk = ~clk;

  intc_cascade u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .nmi_i(nmi),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_valid_o(irq_valid), .irq_level_o(irq_level), .nmi_o(nmi_out)
  );

  int checks = 0, errors = 0;
  bit chk_on = 0, done = 0;

  localparam logic [127:0] SRC = {{124{1'b1}}, 4'b0};

  logic [127:0]     m_flag, m_evtd;
  logic [3:0][31:0] m_mask;
  logic [11:0]      m_sen;
  logic [11:0][6:0] m_sev;
  logic [15:0]      m_en, m_pend;
  logic             m_nmiq, m_nmio;

  function automatic logic [11:0] exp_lines();
    logic [127:0] byp = '0;
    logic [3:0]   cmb;
    logic [11:0]  ln;
    for (int l = 0; l < 12; l++) if (m_sen[l] && m_sev[l] >= 4) byp[m_sev[l]] = 1'b1;
    for (int g = 0; g < 4; g++) cmb[g] = |(m_flag[g*32 +: 32] & ~m_mask[g] & ~byp[g*32 +: 32]);
    for (int l = 0; l < 12; l++) ln[l] = !m_sen[l] ? 1'b0 : (m_sev[l] < 4) ? cmb[m_sev[l][1:0]] : m_flag[m_sev[l]];
    return ln;
  endfunction

  function automatic logic [31:0] model_rd(logic [5:0] a);
    if (a < 4)                 return m_flag[a*32 +: 32];
    if (a >= 8 && a < 12)      return m_mask[a-8];
    if (a >= 16 && a < 28)     return {24'b0, m_sen[a-16], m_sev[a-16]};
    if (a == 32)               return {16'b0, m_en};
    if (a == 33)               return {16'b0, m_pend};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= '0; m_evtd <= '0; m_mask <= '1; m_en <= '0; m_pend <= '0;
      m_nmiq <= 1'b0; m_nmio <= 1'b0;
      for (int l = 0; l < 12; l++) begin
        m_sen[l] <= (l >= 8);
        m_sev[l] <= (l >= 8) ? 7'(l - 8) : 7'd0;
      end
    end else begin
      automatic logic [127:0] c = '0;
      if (we && addr >= 4 && addr < 8) c[(addr-4)*32 +: 32] = wdata;
      m_flag <= (m_flag & ~c) | (evt & ~m_evtd & SRC);
      m_evtd <= evt;
      m_pend <= {exp_lines(), 4'b0};
      m_nmiq <= nmi;
      m_nmio <= nmi & ~m_nmiq;
      if (we) begin
        if (addr >= 8 && addr < 12) m_mask[addr-8] <= wdata;
        if (addr >= 16 && addr < 28) begin
          m_sen[addr-16] <= wdata[7];
          m_sev[addr-16] <= wdata[6:0];
        end
        if (addr == 32) m_en <= wdata[15:0] & 16'hFFF0;
      end
    end
  end

  // continuous comparison of the interrupt outputs against the model
  always @(negedge clk) begin
    if (chk_on) begin
      automatic logic [15:0] act = m_pend & m_en;
      automatic logic        ev = 1'b0;
      automatic logic [3:0]  el = '0;
      for (int l = 15; l >= 4; l--) if (act[l]) begin ev = 1'b1; el = 4'(l); end
      checks++;
      if (irq_valid !== ev || (ev && irq_level !== el)) begin
        errors++;
        $display("FAIL R7 irq valid/level act=%b/%0d exp=%b/%0d", irq_valid, irq_level, ev, el);
      end
      checks++;
      if (nmi_out !== m_nmio) begin
        errors++;
        $display("FAIL R8 nmi_o act=%b exp=%b", nmi_out, m_nmio);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0h act=%h exp=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R1 reset state
    chk(irq_valid == 1'b0, "R1 irq_valid", int'(irq_valid), 0);
    rd(6'h00, 32'h0, "R1 flags");
    rd(6'h08, 32'hFFFF_FFFF, "R1 mask");
    rd(6'h18, 32'h80, "R1 sel12");
    rd(6'h1B, 32'h83, "R1 sel15");
    rd(6'h10, 32'h0, "R1 sel4");
    rd(6'h20, 32'h0, "R1 enable");
    rd(6'h21, 32'h0, "R1 pending");

    // R3 combiner codes cannot be flagged
    @(negedge clk); evt[3:0] = 4'hF;
    idle(2);
    rd(6'h00, 32'h0, "R3 flags0");
    @(negedge clk); evt[3:0] = 4'h0;

    // R2 edge, stickiness, clear, set-wins
    @(negedge clk); evt[40] = 1'b1;
    @(negedge clk); evt[40] = 1'b0;
    idle(1);
    rd(6'h01, 32'h100, "R2 sticky");
    wr(6'h05, 32'h100);
    rd(6'h01, 32'h0, "R2 clear");
    @(negedge clk); evt[41] = 1'b1; we = 1'b1; addr = 6'h05; wdata = 32'h200;
    @(negedge clk); we = 1'b0;
    rd(6'h01, 32'h200, "R2 set wins");
    evt[41] = 1'b0;
    wr(6'h05, 32'h200);

    // R4 combiner to default level 13
    wr(6'h20, 32'hFFF0);
    wr(6'h09, ~32'h100);
    @(negedge clk); evt[40] = 1'b1;
    idle(3);
    chk(irq_valid && irq_level == 4'd13, "R4 comb1 level", int'(irq_level), 13);
    rd(6'h21, 32'h2000, "R6 pending");
    wr(6'h09, 32'hFFFF_FFFF);
    idle(2);
    chk(!irq_valid, "R4 masked", int'(irq_valid), 0);
    wr(6'h09, ~32'h100);

    // R5 direct route to level 5, bypass and mask ignored
    wr(6'h11, 32'h80 | 32'd40);
    idle(2);
    rd(6'h21, 32'h0020, "R5 bypass pending");
    chk(irq_valid && irq_level == 4'd5, "R5 direct level", int'(irq_level), 5);
    wr(6'h09, 32'hFFFF_FFFF);
    idle(2);
    chk(irq_valid && irq_level == 4'd5, "R5 mask no effect", int'(irq_level), 5);

    // R7 priority between two direct levels
    @(negedge clk); evt[70] = 1'b1;
    wr(6'h15, 32'h80 | 32'd70);
    idle(2);
    chk(irq_level == 4'd5, "R7 lower number wins", int'(irq_level), 5);
    wr(6'h20, 32'hFFF0 & ~32'h20);
    idle(1);
    chk(irq_valid && irq_level == 4'd9, "R7 disabled level skipped", int'(irq_level), 9);
    wr(6'h20, 32'h0);
    idle(1);
    chk(!irq_valid, "R7 none enabled", int'(irq_valid), 0);

    // R5 one combiner on two levels
    evt[40] = 1'b0; evt[70] = 1'b0;
    wr(6'h05, 32'hFFFF_FFFF);
    wr(6'h06, 32'hFFFF_FFFF);
    wr(6'h11, 32'h0);
    wr(6'h15, 32'h0);
    wr(6'h10, 32'h82);
    wr(6'h0A, ~32'h800);
    wr(6'h20, 32'hFFF0);
    @(negedge clk); evt[75] = 1'b1;
    idle(3);
    rd(6'h21, 32'h4010, "R5 shared combiner");
    chk(irq_valid && irq_level == 4'd4, "R7 level4 top", int'(irq_level), 4);

    // R8 nmi pulse
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); chk(nmi_out == 1'b1, "R8 pulse high", int'(nmi_out), 1);
    @(negedge clk); chk(nmi_out == 1'b0, "R8 pulse one cycle", int'(nmi_out), 0);
    nmi = 1'b0;

    // R9 map
    rd(6'h3F, 32'h0, "R9 unmapped");
    rd(6'h04, 32'h0, "R9 clear reads 0");
    wr(6'h02, 32'h0);
    rd(6'h02, model_rd(6'h02), "R9 flag write ignored");
    wr(6'h21, 32'hFFFF_FFFF);
    rd(6'h21, model_rd(6'h21), "R9 pending write ignored");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      we = 1'b0;
      for (int w = 0; w < 4; w++) evt[w*32 +: 32] ^= $urandom & $urandom & $urandom & $urandom;
      nmi = ($urandom % 6) == 0;
      case ($urandom % 8)
        0, 1: begin
          we = 1'b1;
          wdata = $urandom;
          case ($urandom % 5)
            0: addr = 6'(4 + $urandom % 4);
            1: addr = 6'(8 + $urandom % 4);
            2: addr = 6'(16 + $urandom % 12);
            3: addr = 6'd32;
            default: addr = 6'($urandom % 64);
          endcase
        end
        2: begin
          addr = 6'($urandom % 64);
          #1;
          checks++;
          if (rdata !== model_rd(addr)) begin
            errors++;
            $display("FAIL R9 random read addr=%0h act=%h exp=%h", addr, rdata, model_rd(addr));
          end
        end
        default: ;
      endcase
    end
    @(negedge clk); we = 1'b0;
    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule